// File: doc/BRIEF.md
# Word-Serial Hash Core Receive/Transmit Port

This block is the slave-side port of a block-oriented hash core. An external controller pushes a message into it one 16-bit word at a time and later pulls the digest out one 16-bit word at a time. Both directions use the same request/acknowledge exchange: the controller raises `load` (with `idata`) or `fetch`. The core answers with a single-cycle `ack` and then rests for one cycle, so every word costs three clock cycles.

Words fill a block buffer. The first word of a block is the most significant. When the last word of a block lands, the port starts the hash engine. While the engine runs, the `busy` pin is high and further loads are not acknowledged. The chaining value the engine leaves behind becomes the starting state for the next block. The `eom` flag, given with the final word of a block, marks that block as the last one of the message. Once that block has been processed, `digest_ready` rises and fetches are served. The hash rounds are stood in for by a stub transform, and padding is assumed to be done upstream. An `init` strobe restores the initial chaining value and clears all word counters before a new message.

Back-pressure rules: a request is a valid that the controller must hold until it sees `ack`. Lowering it earlier withdraws it. `ack` is the only ready indication. The core withholds it for loads during `busy` and after the digest is ready, and for fetches until the digest is ready.

Top module: `hash_word_port`

## Requirements
- R1: After reset, `ack`, `busy` and `digest_ready` are low.
- R2: A request held high from an idle port is acknowledged one cycle later. `ack` stays high for exactly one cycle, and at least two cycles without `ack` follow it. Back-to-back requests therefore complete one word every three cycles.
- R3: The digest has DIGEST_WORDS words, and the chaining state starts at word i = IV_SEED + i (modulo 2^16). For each block, state word i becomes (state word i rotated left by one bit) XOR block word i, where block word 0 is the first word loaded. Fetches return state word 0 first, with `odata` valid while `ack` is high.
- R4: In the cycle after the last word of a block is accepted, `busy` rises. It stays high for ENGINE_CYCLES+1 cycles.
- R5: A load is not acknowledged while `busy` is high. A load held through the busy period is acknowledged in the cycle after `busy` falls.
- R6: `eom` is sampled together with the final word of a block. `digest_ready` rises only when the engine finishes a block that was marked this way. After any other block it stays low.
- R7: A fetch is not acknowledged while `digest_ready` is low.
- R8: Once the last digest word has been fetched, the next fetch returns word 0 again.
- R9: A one-cycle `init` clears `digest_ready`, discards any partly loaded block, restores the initial chaining state and returns the fetch pointer to word 0.
- R10: While `digest_ready` is high, loads are not acknowledged and leave the digest unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Start-of-message strobe; restores the initial state |
| load | input | 1 | Request to deliver one message word; held until `ack` |
| eom | input | 1 | Given with a block's final word; marks that block as the last one |
| idata | input | WORD_W | Message word, valid while `load` is high |
| fetch | input | 1 | Request to read one digest word; held until `ack` |
| ack | output | 1 | One-cycle acknowledge of an accepted load or fetch |
| odata | output | WORD_W | Digest word, valid while a fetch is acknowledged |
| busy | output | 1 | Block complete and engine running; loads are held off |
| digest_ready | output | 1 | Final block processed; digest can be fetched |

## Verification
The bench builds the port with four-word blocks, a four-word digest and a three-cycle engine. This keeps every word slot, the pointer wrap and the whole busy window within a few dozen cycles. It sweeps messages of one to three blocks through a bench model of the chaining transform. It then times loads held across the busy window, fetches and loads refused in the wrong phase, and an `init` that arrives mid-block or after a finished digest.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_ACK  = 2'd1,
    XF_REST = 2'd2
  } xfer_st_e;
endpackage

// File: rtl/hwp_xfer.sv
// Three-cycle request/acknowledge sequencer: accept, acknowledge, rest.
module hwp_xfer
  import hwp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic allow,
  output logic take,
  output logic ack
);
  xfer_st_e st_q;

  assign take = (st_q == XF_IDLE) && req && allow;
  assign ack  = (st_q == XF_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= XF_IDLE;
    end else begin
      unique case (st_q)
        XF_IDLE: if (take) st_q <= XF_ACK;
        XF_ACK:  st_q <= XF_REST;
        default: st_q <= XF_IDLE;
      endcase
    end
  end

  // R2: acknowledge lasts one cycle and is followed by a rest cycle
  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_ack_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |=> !ack);
endmodule

// File: rtl/hwp_engine_stub.sv
// Stand-in for the hash rounds: fixed latency, simple chaining transform.
module hwp_engine_stub #(
  parameter int unsigned W       = 16,
  parameter int unsigned BW      = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned CYC     = 24,
  parameter logic [W-1:0] IV_SEED = 16'h6A09
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            start,
  input  logic [BW*W-1:0] blk,
  output logic            busy,
  output logic            done,
  output logic [DW*W-1:0] state
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0]   cnt_q;
  logic            busy_q;
  logic [DW*W-1:0] st_q, nxt, iv;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_word
      logic [W-1:0] s;
      assign s = st_q[(DW-1-i)*W +: W];
      assign nxt[(DW-1-i)*W +: W] = {s[W-2:0], s[W-1]} ^ blk[(BW-1-i)*W +: W];
      assign iv[(DW-1-i)*W +: W]  = IV_SEED + W'(i);
    end
  endgenerate

  assign busy  = busy_q;
  assign done  = busy_q && (cnt_q == CW'(1));
  assign state = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      st_q   <= iv;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYC);
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
      if (done) begin
        busy_q <= 1'b0;
        st_q   <= nxt;
      end
    end
  end

  // R4: a start always opens a busy window
  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr) |=> busy_q);
  // R3: chaining state moves only when a block completes or on clear
  p_state_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !clr) |=> $stable(st_q));
endmodule

// File: rtl/hash_word_port.sv
module hash_word_port #(
  parameter int unsigned WORD_W        = 16,
  parameter int unsigned BLOCK_WORDS   = 16,
  parameter int unsigned DIGEST_WORDS  = 16,
  parameter int unsigned ENGINE_CYCLES = 24,
  parameter logic [WORD_W-1:0] IV_SEED = 16'h6A09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              load,
  input  logic              eom,
  input  logic [WORD_W-1:0] idata,
  input  logic              fetch,
  output logic              ack,
  output logic [WORD_W-1:0] odata,
  output logic              busy,
  output logic              digest_ready
);
  localparam int unsigned WCW = $clog2(BLOCK_WORDS);
  localparam int unsigned PCW = $clog2(DIGEST_WORDS);
  localparam int unsigned BLK_BITS = BLOCK_WORDS * WORD_W;
  localparam int unsigned DIG_BITS = DIGEST_WORDS * WORD_W;

  logic [BLK_BITS-1:0] blk_q;
  logic [WCW-1:0]      wcnt_q;
  logic [PCW-1:0]      fptr_q;
  logic                go_q, last_q, dig_q;
  logic [WORD_W-1:0]   odata_q;

  logic ld_allow, ld_take, ld_ack;
  logic fe_allow, fe_take, fe_ack;
  logic eng_busy, eng_done;
  logic [DIG_BITS-1:0] st_w;
  logic blk_full;

  assign ld_allow = !init && !go_q && !eng_busy && !dig_q;
  assign fe_allow = !init && dig_q;
  assign blk_full = (wcnt_q == WCW'(BLOCK_WORDS - 1));

  hwp_xfer u_load_xfer (
    .clk(clk), .rst_n(rst_n), .req(load), .allow(ld_allow),
    .take(ld_take), .ack(ld_ack)
  );

  hwp_xfer u_fetch_xfer (
    .clk(clk), .rst_n(rst_n), .req(fetch), .allow(fe_allow),
    .take(fe_take), .ack(fe_ack)
  );

  hwp_engine_stub #(
    .W(WORD_W), .BW(BLOCK_WORDS), .DW(DIGEST_WORDS),
    .CYC(ENGINE_CYCLES), .IV_SEED(IV_SEED)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .clr(init), .start(go_q), .blk(blk_q),
    .busy(eng_busy), .done(eng_done), .state(st_w)
  );

  // Message side: fill buffer first-word-most-significant, fire engine when full
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      wcnt_q <= '0;
      go_q   <= 1'b0;
      last_q <= 1'b0;
      dig_q  <= 1'b0;
    end else if (init) begin
      wcnt_q <= '0;
      go_q   <= 1'b0;
      last_q <= 1'b0;
      dig_q  <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (ld_take) begin
        blk_q[(BLOCK_WORDS-1-int'(wcnt_q))*WORD_W +: WORD_W] <= idata;
        if (blk_full) begin
          wcnt_q <= '0;
          go_q   <= 1'b1;
          last_q <= eom;
        end else begin
          wcnt_q <= wcnt_q + WCW'(1);
        end
      end
      if (eng_done && last_q) dig_q <= 1'b1;
    end
  end

  // Digest side: word-serial read-back with wrapping pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fptr_q  <= '0;
      odata_q <= '0;
    end else if (init) begin
      fptr_q <= '0;
    end else if (fe_take) begin
      odata_q <= st_w[(DIGEST_WORDS-1-int'(fptr_q))*WORD_W +: WORD_W];
      fptr_q  <= (fptr_q == PCW'(DIGEST_WORDS - 1)) ? '0 : fptr_q + PCW'(1);
    end
  end

  assign ack          = ld_ack | fe_ack;
  assign odata        = odata_q;
  assign busy         = go_q | eng_busy;
  assign digest_ready = dig_q;

  // R5: no load acknowledge may follow a busy cycle
  p_load_held_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !ld_ack);
  // R7: fetch acknowledges only with a digest present
  p_fetch_needs_digest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fe_ack |-> digest_ready);
  // R8: pointer returns to word 0 after the last digest word
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_take && fptr_q == PCW'(DIGEST_WORDS - 1) && !init) |=> (fptr_q == '0));
  // R6: digest only after a block flagged as final
  p_ready_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(digest_ready) |-> $past(last_q));
  // R10: no load acknowledge while a digest is being held
  p_no_load_on_digest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (digest_ready && $past(digest_ready)) |-> !ld_ack);
  // R4: start is a single-cycle pulse
  p_go_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !go_q);
  // R2: the two directions never acknowledge together
  p_ack_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_ack && fe_ack));
endmodule

// File: tb/hash_word_port_tb.sv
`timescale 1ns/1ps
module hash_word_port_tb;
  localparam int W   = 16;
  localparam int BW  = 4;
  localparam int DW  = 4;
  localparam int CYC = 3;
  localparam logic [W-1:0] IV = 16'h6A09;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, load = 1'b0, eom = 1'b0, fetch = 1'b0;
  logic [W-1:0] idata = '0;
  logic ack, busy, digest_ready;
  logic [W-1:0] odata;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;
  logic [W-1:0] model [DW];

  always #2 clk = ~clk;

  hash_word_port #(
    .WORD_W(W), .BLOCK_WORDS(BW), .DIGEST_WORDS(DW),
    .ENGINE_CYCLES(CYC), .IV_SEED(IV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .init(init), .load(load), .eom(eom),
    .idata(idata), .fetch(fetch), .ack(ack), .odata(odata),
    .busy(busy), .digest_ready(digest_ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word_of(input int m, input int b, input int k);
    return W'(m * 947 + b * 211 + k * 4099 + 23);
  endfunction

  task automatic model_init();
    for (int i = 0; i < DW; i++) model[i] = IV + W'(i);
  endtask

  task automatic model_block(input int m, input int b);
    for (int i = 0; i < DW; i++)
      model[i] = {model[i][W-2:0], model[i][W-1]} ^ word_of(m, b, i);
  endtask

  task automatic do_load(input logic [W-1:0] d, input bit e, output int w);
    load = 1'b1; idata = d; eom = e; w = 0;
    do begin @(negedge clk); w++; end while (!ack && w < 40);
    load = 1'b0; eom = 1'b0;
    @(negedge clk);
    chk("R2 load ack lasts one cycle", int'(ack), 0);
  endtask

  task automatic do_fetch(output logic [W-1:0] d, output int w);
    fetch = 1'b1; w = 0;
    do begin @(negedge clk); w++; end while (!ack && w < 40);
    d = odata;
    fetch = 1'b0;
    @(negedge clk);
    chk("R2 fetch ack lasts one cycle", int'(ack), 0);
  endtask

  task automatic pulse_init();
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic send_block(input int m, input int b, input bit fin);
    int w, n;
    for (int k = 0; k < BW; k++) begin
      do_load(word_of(m, b, k), fin && (k == BW - 1), w);
      chk("R2 load wait cycles", w, (k == 0) ? 1 : 2);
    end
    chk("R4 busy after block", int'(busy), 1);
    n = 0;
    while (busy && n < 50) begin @(negedge clk); n++; end
    chk("R4 busy window length", n + 1, CYC + 1);
    chk("R6 digest_ready after block", int'(digest_ready), fin ? 1 : 0);
    model_block(m, b);
  endtask

  task automatic read_digest(input string tag, input int count);
    logic [W-1:0] d;
    int w;
    for (int i = 0; i < count; i++) begin
      do_fetch(d, w);
      chk({tag, " fetch wait"}, w, (i == 0) ? 1 : 2);
      if (i < DW) chk({tag, " digest word"}, int'(d), int'(model[i]));
      else chk("R8 pointer wrap", int'(d), int'(model[i % DW]));
    end
  endtask

  initial begin
    int w, hits;
    logic [W-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack after reset", int'(ack), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 digest_ready after reset", int'(digest_ready), 0);

    // R3 R6 R8 R10: sweep messages of 1..3 blocks
    for (int m = 0; m < 3; m++) begin
      pulse_init();
      model_init();
      for (int b = 0; b <= m; b++) send_block(m, b, b == m);
      hits = 0;
      load = 1'b1; idata = 16'hDEAD;
      repeat (6) begin @(negedge clk); if (ack) hits++; end
      load = 1'b0;
      @(negedge clk);
      chk("R10 load refused with digest held", hits, 0);
      read_digest("R3", DW + 1);
    end

    // R9: init resets pointer, partial block and chaining state
    pulse_init();
    chk("R9 digest_ready cleared by init", int'(digest_ready), 0);
    do_load(16'h1111, 1'b0, w);
    do_load(16'h2222, 1'b0, w);
    pulse_init();
    model_init();
    send_block(9, 0, 1'b1);
    read_digest("R9", DW);

    // R7 and R5: fetch refused early; load held across busy window
    pulse_init();
    model_init();
    hits = 0;
    fetch = 1'b1;
    repeat (6) begin @(negedge clk); if (ack) hits++; end
    fetch = 1'b0;
    @(negedge clk);
    chk("R7 fetch refused before digest", hits, 0);
    for (int k = 0; k < BW; k++) do_load(word_of(7, 0, k), 1'b0, w);
    model_block(7, 0);
    do_load(word_of(7, 1, 0), 1'b0, w);
    chk("R5 load held through busy", w, CYC + 1);
    for (int k = 1; k < BW; k++) do_load(word_of(7, 1, k), k == BW - 1, w);
    model_block(7, 1);
    wait_idle();
    @(negedge clk);
    chk("R6 digest_ready after final block", int'(digest_ready), 1);
    read_digest("R5", DW);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule